// File: doc/BRIEF.md
# AXI Decode-Error Subordinate

This block sits behind the interconnect's address decoder as the target for any access that matches no real subordinate. It takes full AXI write and read transactions on the five standard channels and finishes every one of them with a decode-error status. A manager that issues a transaction to an unmapped address therefore always sees it complete.

Write and read paths run on their own, each holding at most one transaction. A write is accepted on the address channel, and its data beats are then drained and thrown away up to the beat flagged as last. Only then is one error response returned. A read returns a burst of exactly the requested length. Every beat carries zero data and an error status, and only the final beat is marked last. The transaction ID from the address phase is echoed on the response.

Top module: `axi_decerr_sub`

## Requirements
- R1: After reset the block shows awready=1 and arready=1, with wready=0, bvalid=0 and rvalid=0.
- R2: The response field uses the 2-bit code 00=OKAY, 01=EXOKAY, 10=SLVERR, 11=DECERR. Whenever bvalid or rvalid is high, the block drives 2'b11 on bresp or rresp.
- R3: Each write gets exactly one B response. bvalid rises on the cycle after the W handshake that carries wlast=1, and not before.
- R4: wready is high only from the cycle after the AW handshake up to and including the W beat with wlast=1.
- R5: awready is high only while the write path holds no transaction. A new AW is accepted on the cycle after the B handshake completes.
- R6: Once bvalid is high, it stays high with bid and bresp unchanged until a cycle with bready=1.
- R7: A read with arlen=L returns exactly L+1 R handshakes.
- R8: rlast is 1 on beat L+1 (counting from 1) and 0 on every earlier beat.
- R9: rdata is all zeros, rid equals the arid of the burst, and bid equals the awid of the write.
- R10: An R beat advances only on a cycle with rvalid=1 and rready=1. While rready=0, rvalid, rlast and rid hold their values.
- R11: arready is 0 from the AR handshake until the beat with rlast=1 has been handshaken. It is 1 again on the next cycle.
- R12: A write and a read can be in progress at the same time without affecting each other's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awid | input | ID_W | Write transaction ID |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wlast | input | 1 | Final write beat marker |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | ID_W | Echoed write ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_arid | input | ID_W | Read transaction ID |
| s_arlen | input | LEN_W | Read burst length minus one |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rid | output | ID_W | Echoed read ID |
| s_rdata | output | DATA_W | Read data (zero) |
| s_rresp | output | 2 | Per-beat read response code |
| s_rlast | output | 1 | Final read beat marker |

## Verification
Each path has one register stage, so results land one cycle after the handshake that causes them. wready and rvalid appear one cycle after the address handshake, and bvalid one cycle after the wlast beat. awready and arready return one cycle after the closing B or final R handshake. The bench drives and samples on the falling edge. A handshake therefore happens at the rising edge that follows a falling edge where both valid and ready were seen high, and the effect is checked at the next falling edge. Read bursts are swept over every length from 0 to 9 plus the maximum, each under several rready stall patterns. Writes are swept over beat counts, data gaps and response back-pressure, and one write is run while a read is in flight.

// File: rtl/axi_decerr_pkg.sv
package axi_decerr_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'b00,
    WR_DATA = 2'b01,
    WR_RESP = 2'b10
  } wr_state_e;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_BEAT = 1'b1
  } rd_state_e;

  // Beat indices count from zero; the burst ends at index == length field.
  function automatic logic is_final_beat(input int unsigned idx,
                                         input int unsigned len_field);
    return idx == len_field;
  endfunction

  function automatic int unsigned beats_in_burst(input int unsigned len_field);
    return len_field + 1;
  endfunction

endpackage

// File: rtl/decerr_wr_path.sv
module decerr_wr_path
  import axi_decerr_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            awvalid,
  output logic            awready,
  input  logic [ID_W-1:0] awid,
  input  logic            wvalid,
  output logic            wready,
  input  logic            wlast,
  output logic            bvalid,
  input  logic            bready,
  output logic [ID_W-1:0] bid,
  output logic            aw_fire,
  output logic            w_fire_last,
  output logic            b_fire
);

  wr_state_e       state_q;
  logic [ID_W-1:0] id_q;

  assign awready     = (state_q == WR_IDLE);
  assign wready      = (state_q == WR_DATA);
  assign bvalid      = (state_q == WR_RESP);
  assign bid         = id_q;
  assign aw_fire     = awvalid && awready;
  assign w_fire_last = wvalid && wready && wlast;
  assign b_fire      = bvalid && bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      id_q    <= '0;
    end else begin
      unique case (state_q)
        WR_IDLE: if (aw_fire) begin
          state_q <= WR_DATA;
          id_q    <= awid;
        end
        WR_DATA: if (w_fire_last) state_q <= WR_RESP;
        WR_RESP: if (b_fire) state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/decerr_rd_path.sv
module decerr_rd_path
  import axi_decerr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [LEN_W-1:0]  arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic              rlast,
  output logic              ar_fire,
  output logic              r_fire,
  output logic              r_fire_last
);

  rd_state_e        state_q;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;

  assign arready     = (state_q == RD_IDLE);
  assign rvalid      = (state_q == RD_BEAT);
  assign rid         = id_q;
  assign rdata       = '0;
  assign rlast       = rvalid && is_final_beat(32'(idx_q), 32'(len_q));
  assign ar_fire     = arvalid && arready;
  assign r_fire      = rvalid && rready;
  assign r_fire_last = r_fire && rlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      id_q    <= '0;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: if (ar_fire) begin
          state_q <= RD_BEAT;
          id_q    <= arid;
          len_q   <= arlen;
          idx_q   <= '0;
        end
        RD_BEAT: if (r_fire_last) begin
          state_q <= RD_IDLE;
        end else if (r_fire) begin
          idx_q <= idx_q + 1'b1;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axi_decerr_sub.sv
module axi_decerr_sub
  import axi_decerr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast
);

  // Named handshake events, used by the bound checker.
  logic aw_fire, w_fire_last, b_fire;
  logic ar_fire, r_fire, r_fire_last;

  decerr_wr_path #(.ID_W(ID_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .awvalid     (s_awvalid),
    .awready     (s_awready),
    .awid        (s_awid),
    .wvalid      (s_wvalid),
    .wready      (s_wready),
    .wlast       (s_wlast),
    .bvalid      (s_bvalid),
    .bready      (s_bready),
    .bid         (s_bid),
    .aw_fire     (aw_fire),
    .w_fire_last (w_fire_last),
    .b_fire      (b_fire)
  );

  decerr_rd_path #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .arvalid     (s_arvalid),
    .arready     (s_arready),
    .arid        (s_arid),
    .arlen       (s_arlen),
    .rvalid      (s_rvalid),
    .rready      (s_rready),
    .rid         (s_rid),
    .rdata       (s_rdata),
    .rlast       (s_rlast),
    .ar_fire     (ar_fire),
    .r_fire      (r_fire),
    .r_fire_last (r_fire_last)
  );

  assign s_bresp = RESP_DECERR;
  assign s_rresp = RESP_DECERR;

endmodule

// File: rtl/decerr_sub_chk.sv
module decerr_sub_chk #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bvalid,
  input logic              bready,
  input logic [ID_W-1:0]   bid,
  input logic [1:0]        bresp,
  input logic              aw_fire,
  input logic              w_fire_last,
  input logic              b_fire,
  input logic              rvalid,
  input logic              rready,
  input logic [ID_W-1:0]   rid,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              rlast,
  input logic [LEN_W-1:0]  arlen,
  input logic              ar_fire,
  input logic              r_fire,
  input logic              r_fire_last
);

  // Independent beat tracking for the read burst.
  logic [LEN_W:0]   cnt_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (ar_fire) begin
      cnt_q <= '0;
      len_q <= arlen;
    end else if (r_fire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_B_DECERR: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b11);  // R2
  AST_R_DECERR: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rresp == 2'b11);  // R2
  AST_B_AFTER_WLAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(w_fire_last));  // R3
  AST_B_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire |=> !bvalid);  // R3
  AST_AW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |-> !bvalid);  // R5
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bid));  // R6
  AST_RLAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    r_fire |-> (rlast == (cnt_q == {1'b0, len_q})));  // R8
  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rdata == '0);  // R9
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rlast) && $stable(rid));  // R10
  AST_AR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |-> !rvalid);  // R11
  AST_RLAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    r_fire_last |=> !rvalid);  // R11

endmodule

bind axi_decerr_sub decerr_sub_chk #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bvalid      (s_bvalid),
  .bready      (s_bready),
  .bid         (s_bid),
  .bresp       (s_bresp),
  .aw_fire     (aw_fire),
  .w_fire_last (w_fire_last),
  .b_fire      (b_fire),
  .rvalid      (s_rvalid),
  .rready      (s_rready),
  .rid         (s_rid),
  .rdata       (s_rdata),
  .rresp       (s_rresp),
  .rlast       (s_rlast),
  .arlen       (s_arlen),
  .ar_fire     (ar_fire),
  .r_fire      (r_fire),
  .r_fire_last (r_fire_last)
);

// File: tb/axi_decerr_sub_tb.sv
`timescale 1ns/1ps
module axi_decerr_sub_tb;
  localparam int ID_W = 4, LEN_W = 8, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, wlast = 0, bready = 0;
  logic arvalid = 0, rready = 0;
  logic [ID_W-1:0] awid = '0, arid = '0;
  logic [LEN_W-1:0] arlen = '0;
  logic awready, wready, bvalid, arready, rvalid, rlast;
  logic [ID_W-1:0] bid, rid;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  axi_decerr_sub #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awid(awid),
    .s_wvalid(wvalid), .s_wready(wready), .s_wlast(wlast),
    .s_bvalid(bvalid), .s_bready(bready), .s_bid(bid), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_arid(arid), .s_arlen(arlen),
    .s_rvalid(rvalid), .s_rready(rready), .s_rid(rid), .s_rdata(rdata),
    .s_rresp(rresp), .s_rlast(rlast)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_burst(input int id, input int n, input int gap, input int bdelay);
    @(negedge clk);
    chk(wready == 0, "R4 wready low while idle", wready, 0);
    awvalid = 1; awid = ID_W'(id);
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        wvalid = 0; wlast = 0;
        chk(bvalid == 0, "R3 no response during gap", bvalid, 0);
        chk(wready == 1, "R4 wready during data phase", wready, 1);
      end
      @(negedge clk);
      wvalid = 1; wlast = (i == n - 1);
      chk(bvalid == 0, "R3 no response before last beat", bvalid, 0);
      chk(wready == 1, "R4 wready before last beat", wready, 1);
      chk(awready == 0, "R5 awready low while busy", awready, 0);
    end
    @(negedge clk);
    wvalid = 0; wlast = 0;
    chk(bvalid == 1, "R3 response one cycle after last beat", bvalid, 1);
    chk(wready == 0, "R4 wready drops after last beat", wready, 0);
    chk(awready == 0, "R5 awready low during response", awready, 0);
    chk(bresp == 2'b11, "R2 bresp is DECERR", bresp, 3);
    chk(bid == ID_W'(id), "R9 bid echoes awid", bid, id);
    for (int d = 0; d < bdelay; d++) begin
      @(negedge clk);
      bready = 0;
      chk(bvalid == 1, "R6 bvalid held", bvalid, 1);
      chk(bid == ID_W'(id), "R6 bid held", bid, id);
    end
    @(negedge clk);
    bready = 1;
    chk(bvalid == 1, "R6 bvalid until bready", bvalid, 1);
    @(negedge clk);
    bready = 0;
    chk(bvalid == 0, "R3 exactly one response", bvalid, 0);
    chk(awready == 1, "R5 awready back after response", awready, 1);
  endtask

  task automatic read_burst(input int id, input int len, input int stall);
    int idx = 0, cyc = 0;
    bit done = 0, prev_stall = 0, prev_last = 0;
    @(negedge clk);
    arvalid = 1; arid = ID_W'(id); arlen = LEN_W'(len);
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    chk(rvalid == 1, "R7 first beat one cycle after AR", rvalid, 1);
    chk(arready == 0, "R11 arready low during burst", arready, 0);
    while (!done && cyc < 2000) begin
      bit rr;
      @(negedge clk);
      rr = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (prev_stall) begin
        chk(rvalid == 1, "R10 rvalid held on stall", rvalid, 1);
        chk(rlast == prev_last, "R10 rlast held on stall", rlast, prev_last);
      end
      rready = rr;
      if (rvalid) begin
        chk(rresp == 2'b11, "R2 rresp is DECERR", rresp, 3);
        chk(rdata == '0, "R9 rdata zero", rdata, 0);
        chk(rid == ID_W'(id), "R9 rid echoes arid", rid, id);
        chk(rlast == (idx == len), "R8 rlast position", rlast, (idx == len));
        chk(arready == 0, "R11 arready low before last handshake", arready, 0);
        prev_last = rlast;
        prev_stall = !rr;
        if (rr) begin
          idx++;
          if (rlast) done = 1;
        end
      end else begin
        prev_stall = 0;
      end
      cyc++;
    end
    @(negedge clk);
    rready = 0;
    chk(idx == len + 1, "R7 beat count", idx, len + 1);
    chk(rvalid == 0, "R7 no beat after last", rvalid, 0);
    chk(arready == 1, "R11 arready back after last", arready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(awready == 1, "R1 awready after reset", awready, 1);
    chk(arready == 1, "R1 arready after reset", arready, 1);
    chk(wready == 0, "R1 wready after reset", wready, 0);
    chk(bvalid == 0, "R1 bvalid after reset", bvalid, 0);
    chk(rvalid == 0, "R1 rvalid after reset", rvalid, 0);

    for (int n = 1; n <= 6; n++)
      for (int gap = 0; gap <= 1; gap++)
        for (int bd = 0; bd <= 2; bd++)
          write_burst((n * 3 + gap + bd) % 16, n, gap, bd);

    for (int len = 0; len <= 9; len++)
      for (int s = 0; s <= 3; s++)
        if (s != 1) read_burst((len * 5 + s) % 16, len, s);
    read_burst(9, 255, 0);
    read_burst(6, 255, 3);

    // R12: a write overlapping a read in flight
    fork
      write_burst(11, 4, 1, 2);
      read_burst(4, 7, 2);
    join

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule